// File: doc/BRIEF.md
# Instruction Pointer Branch Target Unit

This block holds the code segment base and the instruction offset of a real-mode style processor front end. Every cycle it either keeps both registers, steps the offset past the current instruction, or forms a new target from one of five control-transfer rules. The decoder supplies the length of the current instruction, a transfer kind and the operands each rule needs. Those operands are a displacement, a register value, a word already read from memory, and a segment:offset pair taken from the instruction.

The registered offset always names the instruction being executed. Relative targets are therefore measured from the offset plus the instruction length, which is the start of the following instruction. All offset arithmetic wraps within the 64 KiB code segment. The linear fetch address is formed from the registered pair as segment times sixteen plus offset and wraps at 1 MiB. Pushing return addresses and decoding instructions are done elsewhere.

Top module: `flow_target_unit`

## Requirements
- R1: While reset is low, and on leaving it, the segment register holds FFFFh, the offset register holds 0000h and the fetch address reads FFFF0h.
- R2: With `adv` high and `take` low, the offset becomes (offset + `ins_len`) mod 65536 at the next clock edge, and the segment is unchanged.
- R3: With `take` and `adv` both low, neither register changes, whatever the other inputs carry.
- R4: With `take` high and `kind` = 0 (short relative), the offset becomes (offset + `ins_len` + sign-extended `disp[7:0]`) mod 65536. This reaches -128 to +127 bytes from the following instruction. `disp[15:8]` is ignored and the segment is unchanged.
- R5: With `take` high and `kind` = 1 (near relative), the offset becomes (offset + `ins_len` + `disp`) mod 65536, with `disp` taken as a 16-bit two's complement value. The segment is unchanged.
- R6: With `take` high and `kind` = 2 (near through register), the offset becomes `reg_val` and the segment is unchanged.
- R7: With `take` high and `kind` = 3 (near through memory word), the offset becomes `mem_word` and the segment is unchanged. `mem_word` is the word read at the data-segment offset the register held.
- R8: With `take` high and `kind` = 4 (far direct), the segment becomes `far_cs` and the offset becomes `far_ip`. For example, 1000h:0000h gives fetch address 10000h.
- R9: When `take` and `adv` are high together, the transfer rule alone decides the next state and the sequential step is not added.
- R10: With `take` high and `kind` = 5, 6 or 7, neither register changes, even when `adv` is high.
- R11: `fetch_addr` always equals (segment × 16 + offset) mod 2^20, computed from the registered pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take | input | 1 | Control transfer taken this cycle |
| kind | input | 3 | Transfer rule: 0 short rel, 1 near rel, 2 register, 3 memory word, 4 far |
| adv | input | 1 | Sequential step past the current instruction |
| ins_len | input | 4 | Length of the current instruction in bytes |
| disp | input | 16 | Relative displacement (low 8 bits for the short rule) |
| reg_val | input | 16 | Register operand for the register rule |
| mem_word | input | 16 | Word read from memory for the memory rule |
| far_cs | input | 16 | Segment of a far target |
| far_ip | input | 16 | Offset of a far target |
| cs_q | output | 16 | Current code segment |
| ip_q | output | 16 | Current instruction offset |
| fetch_addr | output | 20 | Linear fetch address |

## Verification
All 256 short displacements are swept from four base offsets, two of them near the segment ends. This separates correct sign extension and modulo wrap from a zero-extended or saturated sum, and shows that the upper displacement byte plays no part. Near displacements are swept in steps of 257 over the full 16-bit range, plus the extreme values, to tell the 16-bit rule apart from the short one. Register, memory, far, reserved and simultaneous take/advance cases are each driven with distinct operand values, so a swapped operand is exposed. A grid of segment and offset corners, including FFFFh:0010h, checks the 20-bit fetch wrap.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      XFER_SHORT = 3'd0,
      XFER_NEAR  = 3'd1,
      XFER_REG   = 3'd2,
      XFER_MEMW  = 3'd3,
      XFER_FAR   = 3'd4
   } xfer_kind_e;
endpackage

// File: rtl/ipt_rel_adder.sv
// Forms the sequential offset and the relative target from the registered offset.
module ipt_rel_adder #(
   parameter int IP_W    = 16,
   parameter int SHORT_W = 8,
   parameter int LEN_W   = 4
) (
   input  logic [IP_W-1:0]  ip,
   input  logic [LEN_W-1:0] len,
   input  logic [IP_W-1:0]  disp,
   input  logic             is_short,
   output logic [IP_W-1:0]  seq_ip,
   output logic [IP_W-1:0]  rel_ip
);
   localparam int PAD_W = IP_W - LEN_W;

   logic [IP_W-1:0] short_ext;
   logic [IP_W-1:0] disp_sel;

   generate
      if (SHORT_W < IP_W) begin : g_ext
         assign short_ext = {{(IP_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
      end else begin : g_full
         assign short_ext = disp;
      end
   endgenerate

   assign seq_ip   = ip + {{PAD_W{1'b0}}, len};
   assign disp_sel = is_short ? short_ext : disp;
   assign rel_ip   = seq_ip + disp_sel;
endmodule

// File: rtl/ipt_target_sel.sv
// Chooses the next segment and offset from the transfer rule.
module ipt_target_sel
   import ipt_pkg::*;
#(
   parameter int IP_W  = 16,
   parameter int SEG_W = 16
) (
   input  logic              take,
   input  logic [KIND_W-1:0] kind,
   input  logic              adv,
   input  logic [SEG_W-1:0]  cs,
   input  logic [IP_W-1:0]   ip,
   input  logic [IP_W-1:0]   seq_ip,
   input  logic [IP_W-1:0]   rel_ip,
   input  logic [IP_W-1:0]   reg_val,
   input  logic [IP_W-1:0]   mem_word,
   input  logic [SEG_W-1:0]  far_cs,
   input  logic [IP_W-1:0]   far_ip,
   output logic [SEG_W-1:0]  nxt_cs,
   output logic [IP_W-1:0]   nxt_ip
);
   always_comb begin
      nxt_cs = cs;
      nxt_ip = ip;
      if (take) begin
         case (kind)
            XFER_SHORT, XFER_NEAR: nxt_ip = rel_ip;
            XFER_REG:              nxt_ip = reg_val;
            XFER_MEMW:             nxt_ip = mem_word;
            XFER_FAR: begin
               nxt_cs = far_cs;
               nxt_ip = far_ip;
            end
            default: begin
               nxt_cs = cs;
               nxt_ip = ip;
            end
         endcase
      end else if (adv) begin
         nxt_ip = seq_ip;
      end
   end
endmodule

// File: rtl/ipt_linear_addr.sv
// Segment shifted left plus offset, truncated or padded to the address width.
module ipt_linear_addr #(
   parameter int SEG_W     = 16,
   parameter int IP_W      = 16,
   parameter int SEG_SHIFT = 4,
   parameter int ADDR_W    = 20
) (
   input  logic [SEG_W-1:0]  cs,
   input  logic [IP_W-1:0]   ip,
   output logic [ADDR_W-1:0] addr
);
   localparam int BASE_W = SEG_W + SEG_SHIFT;
   localparam int WIDE_W = ((BASE_W > IP_W) ? BASE_W : IP_W) + 1;

   logic [BASE_W-1:0] base;
   logic [WIDE_W-1:0] sum;

   generate
      if (SEG_SHIFT > 0) begin : g_shift
         assign base = {cs, {SEG_SHIFT{1'b0}}};
      end else begin : g_flat
         assign base = cs;
      end
   endgenerate

   assign sum = WIDE_W'(base) + WIDE_W'(ip);

   generate
      if (ADDR_W <= WIDE_W) begin : g_trunc
         assign addr = sum[ADDR_W-1:0];
      end else begin : g_pad
         assign addr = {{(ADDR_W-WIDE_W){1'b0}}, sum};
      end
   endgenerate
endmodule

// File: rtl/flow_target_unit.sv
module flow_target_unit
   import ipt_pkg::*;
#(
   parameter int              IP_W      = 16,
   parameter int              SEG_W     = 16,
   parameter int              SHORT_W   = 8,
   parameter int              LEN_W     = 4,
   parameter int              SEG_SHIFT = 4,
   parameter int              ADDR_W    = SEG_W + SEG_SHIFT,
   parameter logic [SEG_W-1:0] RESET_CS = 16'hFFFF,
   parameter logic [IP_W-1:0]  RESET_IP = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [2:0]        kind,
   input  logic              adv,
   input  logic [LEN_W-1:0]  ins_len,
   input  logic [IP_W-1:0]   disp,
   input  logic [IP_W-1:0]   reg_val,
   input  logic [IP_W-1:0]   mem_word,
   input  logic [SEG_W-1:0]  far_cs,
   input  logic [IP_W-1:0]   far_ip,
   output logic [SEG_W-1:0]  cs_q,
   output logic [IP_W-1:0]   ip_q,
   output logic [ADDR_W-1:0] fetch_addr
);
   generate
      if (LEN_W >= IP_W) begin : g_bad_len
         $error("LEN_W must be narrower than IP_W");
      end
      if (SHORT_W < 2 || SHORT_W > IP_W) begin : g_bad_short
         $error("SHORT_W must lie in 2..IP_W");
      end
      if (ADDR_W < IP_W) begin : g_bad_addr
         $error("ADDR_W must cover the offset width");
      end
      if (KIND_W != 3) begin : g_bad_kind
         $error("kind port assumes a 3-bit encoding");
      end
   endgenerate

   logic [IP_W-1:0]  seq_ip;
   logic [IP_W-1:0]  rel_ip;
   logic [SEG_W-1:0] nxt_cs;
   logic [IP_W-1:0]  nxt_ip;
   logic             is_short;

   assign is_short = (kind == XFER_SHORT);

   ipt_rel_adder #(
      .IP_W(IP_W), .SHORT_W(SHORT_W), .LEN_W(LEN_W)
   ) i_rel (
      .ip(ip_q), .len(ins_len), .disp(disp), .is_short(is_short),
      .seq_ip(seq_ip), .rel_ip(rel_ip)
   );

   ipt_target_sel #(
      .IP_W(IP_W), .SEG_W(SEG_W)
   ) i_sel (
      .take(take), .kind(kind), .adv(adv), .cs(cs_q), .ip(ip_q),
      .seq_ip(seq_ip), .rel_ip(rel_ip), .reg_val(reg_val),
      .mem_word(mem_word), .far_cs(far_cs), .far_ip(far_ip),
      .nxt_cs(nxt_cs), .nxt_ip(nxt_ip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q <= RESET_CS;
         ip_q <= RESET_IP;
      end else begin
         cs_q <= nxt_cs;
         ip_q <= nxt_ip;
      end
   end

   ipt_linear_addr #(
      .SEG_W(SEG_W), .IP_W(IP_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
   ) i_lin (
      .cs(cs_q), .ip(ip_q), .addr(fetch_addr)
   );
endmodule

// File: rtl/ipt_checker.sv
module ipt_checker #(
   parameter int IP_W    = 16,
   parameter int SEG_W   = 16,
   parameter int SHORT_W = 8,
   parameter int LEN_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             take,
   input logic [2:0]       kind,
   input logic             adv,
   input logic [LEN_W-1:0] ins_len,
   input logic [IP_W-1:0]  disp,
   input logic [IP_W-1:0]  reg_val,
   input logic [IP_W-1:0]  mem_word,
   input logic [SEG_W-1:0] far_cs,
   input logic [IP_W-1:0]  far_ip,
   input logic [SEG_W-1:0] cs_q,
   input logic [IP_W-1:0]  ip_q
);
   logic [IP_W-1:0] step_t;
   logic [IP_W-1:0] near_t;
   logic [IP_W-1:0] short_t;

   always_comb begin
      step_t  = ip_q + IP_W'(ins_len);
      near_t  = step_t + disp;
      short_t = step_t + IP_W'($signed(disp[SHORT_W-1:0]));
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !adv) |=> ($stable(cs_q) && $stable(ip_q)));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !take) |=> (ip_q == $past(step_t) && $stable(cs_q)));

   assert_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind == 3'd0) |=> (ip_q == $past(short_t) && $stable(cs_q)));

   assert_near_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind == 3'd1) |=> (ip_q == $past(near_t) && $stable(cs_q)));

   assert_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind == 3'd2) |=> (ip_q == $past(reg_val) && $stable(cs_q)));

   assert_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind == 3'd3) |=> (ip_q == $past(mem_word) && $stable(cs_q)));

   assert_far_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind == 3'd4) |=> (cs_q == $past(far_cs) && ip_q == $past(far_ip)));

   assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && adv && kind == 3'd2) |=> (ip_q == $past(reg_val)));

   assert_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind > 3'd4) |=> ($stable(cs_q) && $stable(ip_q)));
endmodule

bind flow_target_unit ipt_checker #(
   .IP_W(IP_W), .SEG_W(SEG_W), .SHORT_W(SHORT_W), .LEN_W(LEN_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .take(take), .kind(kind), .adv(adv),
   .ins_len(ins_len), .disp(disp), .reg_val(reg_val), .mem_word(mem_word),
   .far_cs(far_cs), .far_ip(far_ip), .cs_q(cs_q), .ip_q(ip_q)
);

// File: tb/test_flow_target_unit.sv
`timescale 1ns/1ps
module test_flow_target_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take = 1'b0;
   logic [2:0]  kind = 3'd0;
   logic        adv = 1'b0;
   logic [3:0]  ins_len = 4'd0;
   logic [15:0] disp = 16'h0, reg_val = 16'h0, mem_word = 16'h0;
   logic [15:0] far_cs = 16'h0, far_ip = 16'h0;
   logic [15:0] cs_q, ip_q;
   logic [19:0] fetch_addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [15:0] m_cs = 16'hFFFF;
   logic [15:0] m_ip = 16'h0000;

   always #2.5 clk = ~clk;

   flow_target_unit i_flow_target_unit (
      .clk(clk), .rst_n(rst_n), .take(take), .kind(kind), .adv(adv),
      .ins_len(ins_len), .disp(disp), .reg_val(reg_val), .mem_word(mem_word),
      .far_cs(far_cs), .far_ip(far_ip), .cs_q(cs_q), .ip_q(ip_q),
      .fetch_addr(fetch_addr)
   );

   task automatic chk(input string rq, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic logic [19:0] lin(input logic [15:0] s, input logic [15:0] o);
      int unsigned v;
      v = int'(s) * 16 + int'(o);
      return 20'(v % 1048576);
   endfunction

   task automatic check_all(input string rq);
      chk(rq, "cs", {16'h0, cs_q}, {16'h0, m_cs});
      chk(rq, "ip", {16'h0, ip_q}, {16'h0, m_ip});
      chk("R11", "addr", {12'h0, fetch_addr}, {12'h0, lin(m_cs, m_ip)});
   endtask

   task automatic op(input bit tk, input logic [2:0] kd, input bit ad,
                     input logic [3:0] ln, input logic [15:0] ds,
                     input logic [15:0] rv, input logic [15:0] mw,
                     input logic [15:0] fc, input logic [15:0] fi,
                     input string rq);
      @(negedge clk);
      take = tk; kind = kd; adv = ad; ins_len = ln; disp = ds;
      reg_val = rv; mem_word = mw; far_cs = fc; far_ip = fi;
      if (tk) begin
         case (kd)
            3'd0: m_ip = 16'(int'(m_ip) + int'(ln) + int'($signed(ds[7:0])));
            3'd1: m_ip = 16'(int'(m_ip) + int'(ln) + int'($signed(ds)));
            3'd2: m_ip = rv;
            3'd3: m_ip = mw;
            3'd4: begin m_cs = fc; m_ip = fi; end
            default: ;
         endcase
      end else if (ad) begin
         m_ip = 16'((int'(m_ip) + int'(ln)) % 65536);
      end
      @(posedge clk);
      #1;
      check_all(rq);
   endtask

   task automatic go_far(input logic [15:0] c, input logic [15:0] i);
      op(1'b1, 3'd4, 1'b0, 4'd5, 16'h1111, 16'h2222, 16'h3333, c, i, "R8");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check_all("R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check_all("R1");

      // R3: idle with busy operands
      op(1'b0, 3'd4, 1'b0, 4'd7, 16'h7F7F, 16'hABCD, 16'h1357, 16'h4444, 16'h5555, "R3");
      op(1'b0, 3'd1, 1'b0, 4'd15, 16'h8000, 16'h0001, 16'h0002, 16'h0003, 16'h0004, "R3");

      // R2: sequential steps of every length, then wrap
      for (int l = 0; l < 16; l++)
         op(1'b0, 3'd0, 1'b1, 4'(l), 16'hFFFF, 16'h0, 16'h0, 16'h9999, 16'h9999, "R2");
      go_far(16'h0040, 16'hFFFE);
      op(1'b0, 3'd4, 1'b1, 4'd3, 16'h0, 16'h0, 16'h0, 16'h1234, 16'h5678, "R2");

      // R4: every short displacement from four bases, junk in the upper byte
      begin
         logic [15:0] bases [4];
         bases[0] = 16'h0000; bases[1] = 16'h0080;
         bases[2] = 16'h7FF0; bases[3] = 16'hFFF8;
         for (int b = 0; b < 4; b++)
            for (int d = 0; d < 256; d++) begin
               go_far(16'h2000, bases[b]);
               op(1'b1, 3'd0, 1'b0, 4'd2, {8'hA5, 8'(d)}, 16'h0, 16'h0, 16'h0, 16'h0, "R4");
            end
      end

      // R5: near displacements across the 16-bit range
      for (int d = 0; d < 65536; d += 257) begin
         go_far(16'h3000, 16'h8000);
         op(1'b1, 3'd1, 1'b0, 4'd3, 16'(d), 16'h0, 16'h0, 16'h0, 16'h0, "R5");
      end
      go_far(16'h3000, 16'h0010);
      op(1'b1, 3'd1, 1'b0, 4'd3, 16'h7FFF, 16'h0, 16'h0, 16'h0, 16'h0, "R5");
      op(1'b1, 3'd1, 1'b0, 4'd3, 16'h8000, 16'h0, 16'h0, 16'h0, 16'h0, "R5");

      // R6 / R7: register and memory word rules with distinct operands
      op(1'b1, 3'd2, 1'b0, 4'd2, 16'h0101, 16'h1000, 16'hDEAD, 16'h7777, 16'h8888, "R6");
      op(1'b1, 3'd2, 1'b0, 4'd2, 16'h0101, 16'hFFFF, 16'h0000, 16'h7777, 16'h8888, "R6");
      op(1'b1, 3'd3, 1'b0, 4'd3, 16'h0202, 16'hBEEF, 16'h2468, 16'h7777, 16'h8888, "R7");
      op(1'b1, 3'd3, 1'b0, 4'd3, 16'h0202, 16'h0000, 16'hFFFE, 16'h7777, 16'h8888, "R7");

      // R8: far targets
      go_far(16'h1000, 16'h0000);
      chk("R8", "far 10000h", {12'h0, fetch_addr}, 32'h0001_0000);
      go_far(16'hABCD, 16'h1234);

      // R9: take and adv together, each rule
      for (int k = 0; k < 5; k++)
         op(1'b1, 3'(k), 1'b1, 4'd6, 16'hFF90, 16'h4321, 16'h8765, 16'h0FED, 16'hCBA9, "R9");

      // R10: reserved kinds leave state alone, even with adv
      for (int k = 5; k < 8; k++)
         op(1'b1, 3'(k), 1'b1, 4'd9, 16'h0033, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "R10");

      // R11: fetch address corners
      begin
         logic [15:0] segs [4];
         logic [15:0] offs [4];
         segs[0] = 16'h0000; segs[1] = 16'hFFFF; segs[2] = 16'h1234; segs[3] = 16'hF000;
         offs[0] = 16'h0000; offs[1] = 16'h0010; offs[2] = 16'hFFFF; offs[3] = 16'hFFF0;
         for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
               go_far(segs[s], offs[o]);
         go_far(16'hFFFF, 16'h0010);
         chk("R11", "wrap to 0", {12'h0, fetch_addr}, 32'h0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule